// File: doc/BRIEF.md
# Receive FIFO and FIFO Control for a 16550-Class Serial Port

This block sits between a serial deserialiser and the host register file of a 16550-class UART. It stores received bytes and owns the FIFO control register, and from these it reports the byte at the head of the queue, the fill level, and the line flags for data ready, overrun and break. It also reports the selected interrupt trigger level and a character-timeout flag. Interrupt prioritisation is done elsewhere, from these outputs.

When the FIFO is enabled, up to 16 bytes are queued. A byte that arrives while the queue is full is dropped and flags an overrun. When the FIFO is disabled, a single holding byte is used, and a new byte replaces it. The timeout counts pulses on a character-time tick input. It raises a flag when four character times pass with data waiting and no host activity. The host reads the head byte by pulsing the read strobe and sampling the data output in the same cycle.

Top module: `rx_fifo_ctrl`

## Requirements
- R1: With the FIFO enabled (control bit 0 = 1), accepted bytes are returned in arrival order. count_o tracks the fill level up to 16, and data_rdy_o is high exactly while count_o is non-zero.
- R2: A push while count_o is 16 and with no read in the same cycle stores nothing. It sets overrun_o and leaves the queued bytes and count_o unchanged. overrun_o stays set until a stat_rd_i pulse.
- R3: Control bits 7:6 select trig_lvl_o: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. The reset value is 1.
- R4: A control write that differs from the stored value and has bit 1 set empties the receive queue and clears timeout_o and brk_o. If the write has bit 2 set, tx_flush_o is high for exactly the one cycle after the write.
- R5: A control write that changes bit 0 performs both flushes of R4 even when bits 1 and 2 are zero.
- R6: ctl_o keeps only bits 7, 6, 3 and 0 of a write (mask 0xC9). A write equal to ctl_o has no effect on the queue or on tx_flush_o.
- R7: Each push restarts a timer of four char_tick_i pulses. timeout_o rises on the fourth pulse if the queue still holds data, and stays low if the queue has emptied.
- R8: A read clears timeout_o. A read that leaves data restarts the four-tick timer, and a read that empties the queue clears brk_o.
- R9: brk_i pushes a 0x00 byte (or, when the FIFO is disabled, loads it) and sets brk_o and data ready. A stat_rd_i pulse clears brk_o and overrun_o.
- R10: With the FIFO disabled, a push loads the holding byte and sets data_rdy_o. A push while data_rdy_o is set replaces the byte and sets overrun_o, and a read clears data_rdy_o.
- R11: A read of an empty FIFO returns 0x00 and leaves the queue unchanged, so later bytes are returned correctly.
- R12: A push and a read in the same cycle on a non-empty FIFO return the head byte, keep count_o unchanged and queue the new byte.
- R13: After reset, the FIFO is disabled, ctl_o is 0x00, and all flags, count_o and tx_flush_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Received byte strobe |
| push_data_i | input | 8 | Received byte |
| brk_i | input | 1 | Break detected strobe |
| rd_i | input | 1 | Host read of the receive buffer |
| stat_rd_i | input | 1 | Host read of line status; clears overrun and break |
| ctl_we_i | input | 1 | FIFO control register write strobe |
| ctl_wdata_i | input | 8 | FIFO control write value |
| char_tick_i | input | 1 | One pulse per character time |
| rd_data_o | output | 8 | Head byte, valid during a read |
| count_o | output | 5 | Bytes queued |
| data_rdy_o | output | 1 | Data ready flag |
| overrun_o | output | 1 | Overrun flag |
| brk_o | output | 1 | Break flag |
| trig_lvl_o | output | 5 | Selected trigger level in bytes |
| timeout_o | output | 1 | Character timeout pending |
| fifo_en_o | output | 1 | FIFO enabled |
| ctl_o | output | 8 | Retained control value |
| tx_flush_o | output | 1 | One-cycle transmit FIFO flush pulse |

## Verification
The queue is first run through a vector table that interleaves pushes, reads, a simultaneous push and read, and reads of an empty queue. Each row checks both the head byte and the fill level, which separates ordering faults from counting faults. A full sixteen-byte fill followed by an extra push shows whether the write pointer wraps correctly and whether an overrun ever overwrites stored data. Tick sequences of three and then four pulses, each with and without an intervening read, show whether the timer re-arms on reads that leave data and stays quiet once the queue has emptied. Control writes are tried with flush bits set, with only the enable bit changing, and with a value equal to the stored one, to show which writes flush and which have no effect.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned CTL_W = 8;
  localparam int unsigned LVL_W = 5;
  localparam logic [CTL_W-1:0] CTL_KEEP = 8'hC9;
  localparam int unsigned B_EN = 0;
  localparam int unsigned B_RXF = 1;
  localparam int unsigned B_TXF = 2;

  typedef struct packed {
    logic en_chg;
    logic rx_flush;
    logic tx_flush;
  } ctl_act_t;

  function automatic logic [LVL_W-1:0] trig_of(input logic [1:0] sel);
    case (sel)
      2'b00:   trig_of = LVL_W'(1);
      2'b01:   trig_of = LVL_W'(4);
      2'b10:   trig_of = LVL_W'(8);
      default: trig_of = LVL_W'(14);
    endcase
  endfunction
endpackage

// File: rtl/rxf_ctl_reg.sv
module rxf_ctl_reg
  import rxf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] ctl_o,
  output ctl_act_t         act_o,
  output logic             tx_flush_o
);
  logic [CTL_W-1:0] ctl_q;
  logic             tx_flush_q;

  always_comb begin
    act_o = '0;
    if (we_i && (wdata_i != ctl_q)) begin
      act_o.en_chg   = wdata_i[B_EN] ^ ctl_q[B_EN];
      act_o.rx_flush = wdata_i[B_RXF] | act_o.en_chg;
      act_o.tx_flush = wdata_i[B_TXF] | act_o.en_chg;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= '0;
      tx_flush_q <= 1'b0;
    end else begin
      if (we_i && (wdata_i != ctl_q)) ctl_q <= wdata_i & CTL_KEEP;
      tx_flush_q <= act_o.tx_flush;
    end
  end

  assign ctl_o      = ctl_q;
  assign tx_flush_o = tx_flush_q;
endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] mem_q [DEPTH];
  logic          rd_ok, wr_ok;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    nxt = (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign rd_ok   = rd_i & ~empty_o;
  // a read in the same cycle frees the slot a full queue needs
  assign wr_ok   = wr_i & (~full_o | rd_ok);

  always_ff @(posedge clk_i) begin
    if (wr_ok && !clr_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= nxt(wp_q);
      if (rd_ok) rp_q <= nxt(rp_q);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = empty_o ? '0 : mem_q[rp_q];
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/rxf_timeout.sv
module rxf_timeout #(
  parameter int unsigned TMO_CHARS = 4,
  localparam int unsigned TW       = $clog2(TMO_CHARS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic arm_i,
  input  logic disarm_i,
  input  logic ack_i,
  input  logic tick_i,
  input  logic present_i,
  output logic pend_o
);
  logic [TW-1:0] cnt_q;
  logic          armed_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (ack_i) pend_q <= 1'b0;
      if (arm_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (disarm_i) begin
        armed_q <= 1'b0;
      end else if (armed_q && tick_i) begin
        if (cnt_q == TW'(TMO_CHARS - 1)) begin
          armed_q <= 1'b0;
          if (present_i) pend_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + TW'(1);
        end
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned DW        = 8,
  parameter int unsigned TMO_CHARS = 4,
  localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             brk_i,
  input  logic             rd_i,
  input  logic             stat_rd_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             char_tick_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [CW-1:0]    count_o,
  output logic             data_rdy_o,
  output logic             overrun_o,
  output logic             brk_o,
  output logic [LVL_W-1:0] trig_lvl_o,
  output logic             timeout_o,
  output logic             fifo_en_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             tx_flush_o
);
  ctl_act_t      act;
  logic          en, rx_clr;
  logic          push_any;
  logic [DW-1:0] push_byte;
  logic          st_wr, st_rd, st_full, st_empty;
  logic [DW-1:0] st_rdata;
  logic [CW-1:0] st_cnt;
  logic          rd_eff, leaves_data, ovf_fifo, ovf_hold, empties;
  logic [DW-1:0] hold_q;
  logic          hold_vld_q, ovr_q, brk_q;

  rxf_ctl_reg u_ctl (
    .clk_i, .rst_ni,
    .we_i       (ctl_we_i),
    .wdata_i    (ctl_wdata_i),
    .ctl_o      (ctl_o),
    .act_o      (act),
    .tx_flush_o (tx_flush_o)
  );

  assign en        = ctl_o[B_EN];
  assign rx_clr    = act.rx_flush;
  assign push_any  = push_i | brk_i;
  assign push_byte = brk_i ? '0 : push_data_i;
  assign st_wr     = en & push_any;
  assign st_rd     = en & rd_i;

  rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .clr_i   (rx_clr),
    .wr_i    (st_wr),
    .wdata_i (push_byte),
    .rd_i    (st_rd),
    .rdata_o (st_rdata),
    .cnt_o   (st_cnt),
    .full_o  (st_full),
    .empty_o (st_empty)
  );

  assign rd_eff      = st_rd & ~st_empty;
  assign leaves_data = rd_eff & ((st_cnt > CW'(1)) | st_wr);
  assign ovf_fifo    = st_wr & st_full & ~rd_eff & ~rx_clr;
  assign ovf_hold    = ~en & push_any & hold_vld_q & ~rd_i & ~rx_clr;
  assign empties     = en ? (rd_eff & ~leaves_data) : (rd_i & ~push_any);

  rxf_timeout #(.TMO_CHARS(TMO_CHARS)) u_tmo (
    .clk_i, .rst_ni,
    .clr_i     (rx_clr | ~en),
    .arm_i     (st_wr | leaves_data),
    .disarm_i  (rd_eff & ~leaves_data),
    .ack_i     (rd_i),
    .tick_i    (char_tick_i),
    .present_i (~st_empty),
    .pend_o    (timeout_o)
  );

  // single holding byte used while the FIFO is disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else if (rx_clr) begin
      hold_vld_q <= 1'b0;
    end else if (!en) begin
      if (push_any) begin
        hold_q     <= push_byte;
        hold_vld_q <= 1'b1;
      end else if (rd_i) begin
        hold_vld_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      if (ovf_fifo || ovf_hold) ovr_q <= 1'b1;
      else if (stat_rd_i)       ovr_q <= 1'b0;
      if (rx_clr)                          brk_q <= 1'b0;
      else if (brk_i)                      brk_q <= 1'b1;
      else if (stat_rd_i || empties)       brk_q <= 1'b0;
    end
  end

  assign rd_data_o  = en ? st_rdata : hold_q;
  assign count_o    = st_cnt;
  assign data_rdy_o = en ? ~st_empty : hold_vld_q;
  assign overrun_o  = ovr_q;
  assign brk_o      = brk_q;
  assign trig_lvl_o = trig_of(ctl_o[7:6]);
  assign fifo_en_o  = en;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             brk_i,
  input logic             rd_i,
  input logic             ctl_we_i,
  input logic [CTL_W-1:0] ctl_wdata_i,
  input logic [DW-1:0]    rd_data_o,
  input logic [CW-1:0]    count_o,
  input logic             overrun_o,
  input logic [LVL_W-1:0] trig_lvl_o,
  input logic             timeout_o,
  input logic             fifo_en_o,
  input logic [CTL_W-1:0] ctl_o,
  input logic             tx_flush_o
);
  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  a_r2_full_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_o && push_i && !rd_i && !ctl_we_i && count_o == CW'(DEPTH)
    |=> overrun_o && $stable(count_o));

  a_r3_trig_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_lvl_o == 5'd1 || trig_lvl_o == 5'd4 || trig_lvl_o == 5'd8 || trig_lvl_o == 5'd14);

  a_r4_tx_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_wdata_i[B_TXF] && ctl_wdata_i != ctl_o |=> tx_flush_o);

  a_r5_toggle_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_wdata_i[B_EN] != fifo_en_o |=> tx_flush_o && count_o == '0);

  a_r6_ctl_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o & ~CTL_KEEP) == '0);

  a_r8_read_clears_tmo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !timeout_o);

  a_r11_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_o && count_o == '0 |-> rd_data_o == '0);

  a_r12_simul: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_o && push_i && !brk_i && rd_i && !ctl_we_i && count_o != '0
    |=> $stable(count_o));
endmodule

bind rx_fifo_ctrl rxf_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .brk_i       (brk_i),
  .rd_i        (rd_i),
  .ctl_we_i    (ctl_we_i),
  .ctl_wdata_i (ctl_wdata_i),
  .rd_data_o   (rd_data_o),
  .count_o     (count_o),
  .overrun_o   (overrun_o),
  .trig_lvl_o  (trig_lvl_o),
  .timeout_o   (timeout_o),
  .fifo_en_o   (fifo_en_o),
  .ctl_o       (ctl_o),
  .tx_flush_o  (tx_flush_o)
);

// File: tb/rx_fifo_ctrl_bench.sv
module rx_fifo_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       push_i = 1'b0, brk_i = 1'b0, rd_i = 1'b0, stat_rd_i = 1'b0;
  logic       ctl_we_i = 1'b0, char_tick_i = 1'b0;
  logic [7:0] push_data_i = '0, ctl_wdata_i = '0;
  logic [7:0] rd_data_o, ctl_o;
  logic [4:0] count_o, trig_lvl_o;
  logic       data_rdy_o, overrun_o, brk_o, timeout_o, fifo_en_o, tx_flush_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  rx_fifo_ctrl u_rx_fifo_ctrl (.*);

  // {push, data, rd, exp_rd_data, exp_count}
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 8'hA1, 1'b0, 8'h00, 5'd1},
    {1'b1, 8'hB2, 1'b0, 8'h00, 5'd2},
    {1'b1, 8'hC3, 1'b0, 8'h00, 5'd3},
    {1'b0, 8'h00, 1'b1, 8'hA1, 5'd2},
    {1'b1, 8'hD4, 1'b1, 8'hB2, 5'd2},
    {1'b0, 8'h00, 1'b1, 8'hC3, 5'd1},
    {1'b0, 8'h00, 1'b1, 8'hD4, 5'd0},
    {1'b0, 8'h00, 1'b1, 8'h00, 5'd0},
    {1'b1, 8'hE5, 1'b0, 8'h00, 5'd1},
    {1'b0, 8'h00, 1'b1, 8'hE5, 5'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic push(input logic [7:0] b);
    push_i = 1'b1; push_data_i = b; step(); push_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] exp);
    rd_i = 1'b1; #1; chk(req, rd_data_o, exp); step(); rd_i = 1'b0;
  endtask

  task automatic ctl(input logic [7:0] v);
    ctl_we_i = 1'b1; ctl_wdata_i = v; step(); ctl_we_i = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      char_tick_i = 1'b1; step(); char_tick_i = 1'b0;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    step();
    // R13 reset state
    chk("R13 count", count_o, 0);
    chk("R13 flags", {data_rdy_o, overrun_o, brk_o, timeout_o, fifo_en_o, tx_flush_o}, 0);
    chk("R13 ctl", ctl_o, 8'h00);
    chk("R13 trig", trig_lvl_o, 1);

    // R5 enabling forces flushes
    ctl(8'h01);
    chk("R5 tx_flush on enable", tx_flush_o, 1);
    chk("R5 fifo_en", fifo_en_o, 1);
    step();
    chk("R4 tx_flush one cycle", tx_flush_o, 0);

    // R1 R11 R12 vector walk
    for (int i = 0; i < NV; i++) begin
      push_i = VEC[i][22]; push_data_i = VEC[i][21:14]; rd_i = VEC[i][13];
      #1;
      if (VEC[i][13]) chk($sformatf("R1/R11/R12 row %0d data", i), rd_data_o, VEC[i][12:5]);
      step();
      push_i = 1'b0; rd_i = 1'b0;
      chk($sformatf("R1/R11/R12 row %0d count", i), count_o, VEC[i][4:0]);
    end

    // R3 trigger levels
    ctl(8'hC1); chk("R3 lvl 14", trig_lvl_o, 14);
    ctl(8'h41); chk("R3 lvl 4", trig_lvl_o, 4);
    ctl(8'h81); chk("R3 lvl 8", trig_lvl_o, 8);
    ctl(8'h01); chk("R3 lvl 1", trig_lvl_o, 1);

    // R6 mask
    ctl(8'hFF);
    chk("R6 mask", ctl_o, 8'hC9);
    chk("R4 tx_flush bit2", tx_flush_o, 1);
    ctl(8'h01);

    // R1 R2 fill, overrun, wrap
    for (int i = 0; i < 16; i++) push(8'(i + 8'h10));
    chk("R1 full count", count_o, 16);
    push(8'h77);
    chk("R2 overrun", overrun_o, 1);
    chk("R2 count kept", count_o, 16);
    for (int i = 0; i < 16; i++) rd("R2 data kept", 8'(i + 8'h10));
    chk("R1 drained", {count_o, data_rdy_o}, 0);
    stat_rd_i = 1'b1; step(); stat_rd_i = 1'b0;
    chk("R9 stat clears overrun", overrun_o, 0);

    // R7 timeout
    push(8'h31);
    tick(3); chk("R7 no timeout at 3", timeout_o, 0);
    tick(1); chk("R7 timeout at 4", timeout_o, 1);
    rd("R8 read data", 8'h31);
    chk("R8 read clears timeout", timeout_o, 0);

    // R8 restart on non-emptying read
    push(8'h41); push(8'h42);
    tick(3);
    rd("R8 data", 8'h41);
    tick(3); chk("R8 restarted", timeout_o, 0);
    tick(1); chk("R8 fires after restart", timeout_o, 1);
    rd("R8 data2", 8'h42);

    // R7 emptied queue stays quiet
    push(8'h51); rd("R7 data", 8'h51);
    tick(4); chk("R7 no data no timeout", timeout_o, 0);

    // R9 break
    brk_i = 1'b1; step(); brk_i = 1'b0;
    chk("R9 break flags", {brk_o, data_rdy_o, count_o}, {1'b1, 1'b1, 5'd1});
    rd("R9 zero byte", 8'h00);
    chk("R8 empty read clears break", {brk_o, data_rdy_o}, 0);

    // R4 rx flush clears timeout
    push(8'h61); push(8'h62); tick(4);
    chk("R4 pre timeout", timeout_o, 1);
    ctl(8'h03);
    chk("R4 flushed", {count_o, data_rdy_o, timeout_o, tx_flush_o}, 0);
    chk("R4 ctl kept", ctl_o, 8'h01);

    // R6 equal write no effect
    push(8'h71); push(8'h72);
    ctl(8'h01);
    chk("R6 equal write", {count_o, tx_flush_o}, {5'd2, 1'b0});

    // R5 disable flushes
    ctl(8'h00);
    chk("R5 disable flush", {count_o, tx_flush_o, fifo_en_o}, {5'd0, 1'b1, 1'b0});

    // R10 holding register
    push(8'h5A);
    chk("R10 dr", data_rdy_o, 1);
    push(8'h6B);
    chk("R10 overrun", overrun_o, 1);
    rd("R10 replaced", 8'h6B);
    chk("R10 read clears dr", data_rdy_o, 0);
    stat_rd_i = 1'b1; step(); stat_rd_i = 1'b0;
    chk("R9 stat clears", {overrun_o, brk_o}, 0);

    summary();
  end
endmodule